// File: doc/BRIEF.md
# Dual-Sided Semaphore Token Bank

This block holds a small bank of hardware semaphore flags that two agents, a left side and a right side, use to agree on who owns a shared resource. Each flag is a token that at most one side may hold at any time. A side reaches the bank through its own semaphore select. This path is separate from any memory enable, so the flags sit in an address space of their own. A narrow address picks one flag, and only the least significant data bit of a write matters.

The polarity is active low. A side asks for a token by writing a zero and gives it back by writing a one. Reading a flag returns all zeros when the reading side holds the token and all ones otherwise. A request that meets a token held by the other side is not lost. The bank remembers it and hands the token over on the same edge that the owner releases it. When both sides ask for a free flag in the same cycle, the left side wins and the right request waits.

All logic is synchronous to one clock and uses an active-high synchronous reset. Read data is registered and holds its value between reads.

Top module: `sem_token_bank`

## Requirements
- R1: After reset, every flag is free, and both read-data outputs are all ones (16'hFFFF).
- R2: When a side's select input is low, its write, read and address inputs have no effect on any flag or on its read data.
- R3: A write with data bit 0 equal to 0 to a free flag gives the token to the writing side. Data bits 15..1 are ignored. At most one side owns a flag at any time.
- R4: A read (select high, write low) returns the flag's state one clock later on all 16 bits: 16'h0000 if the reading side owns the token, 16'hFFFF otherwise. The read-data output keeps its value in cycles with no read.
- R5: A write with data bit 0 equal to 1 from the owning side frees the flag. The same write from a side that does not own the flag never frees it.
- R6: A request against a flag the other side holds is remembered. When the owner releases, the token passes straight to the waiting side on that same edge.
- R7: If both sides request the same free flag in the same cycle, the left side receives the token and the right request is remembered as waiting.
- R8: A release write from a side that is waiting but does not own the flag withdraws its waiting request.
- R9: The address (3 bits for 8 flags) selects one flag. Operations on one flag leave every other flag unchanged.
- R10: A request from the side that already owns the flag leaves ownership unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left semaphore select |
| l_wr | input | 1 | Left write (1) or read (0) |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 16 | Left write data, bit 0 used |
| l_rdata | output | 16 | Left registered read data |
| r_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right write (1) or read (0) |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 16 | Right write data, bit 0 used |
| r_rdata | output | 16 | Right registered read data |

## Verification
The hardest case to reach is a hand-over that happens on the same edge as another event: an owner release landing in the same cycle as the waiting side's own request or withdrawal, or a tied request on a free flag. Reaching any of these needs both ports to hit one flag in carefully aligned cycles. Directed sequences first build each of these situations on purpose. A long random phase then narrows both ports' addresses to a few flags, so that collisions, waiting requests and withdrawals occur often. A behavioural model checks both read ports on every clock.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } holder_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 3
) (
  input  logic                 sel,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 bit0,
  output logic [NUM_FLAGS-1:0] req,
  output logic [NUM_FLAGS-1:0] rel,
  output logic                 rd
);
  logic [NUM_FLAGS-1:0] hit;

  always_comb begin
    hit = '0;
    if (sel && wr) hit = NUM_FLAGS'(1) << addr;
    req = bit0 ? '0 : hit;
    rel = bit0 ? hit : '0;
    rd  = sel && !wr;
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic own_l,
  output logic own_r
);
  holder_e holder_q, holder_d;
  logic    wait_l_q, wait_l_d;
  logic    wait_r_q, wait_r_d;

  always_comb begin
    holder_d = holder_q;
    wait_l_d = wait_l_q;
    wait_r_d = wait_r_q;
    case (holder_q)
      HOLD_NONE: begin
        if (req_l) begin
          holder_d = HOLD_LEFT;
          wait_r_d = req_r;
        end else if (req_r) begin
          holder_d = HOLD_RIGHT;
        end
      end
      HOLD_LEFT: begin
        wait_l_d = 1'b0;
        if (rel_l) begin
          if (wait_r_q || req_r) holder_d = HOLD_RIGHT;
          else                   holder_d = HOLD_NONE;
          wait_r_d = 1'b0;
        end else begin
          if (req_r) wait_r_d = 1'b1;
          if (rel_r) wait_r_d = 1'b0;
        end
      end
      HOLD_RIGHT: begin
        wait_r_d = 1'b0;
        if (rel_r) begin
          if (wait_l_q || req_l) holder_d = HOLD_LEFT;
          else                   holder_d = HOLD_NONE;
          wait_l_d = 1'b0;
        end else begin
          if (req_l) wait_l_d = 1'b1;
          if (rel_l) wait_l_d = 1'b0;
        end
      end
      default: begin
        holder_d = HOLD_NONE;
        wait_l_d = 1'b0;
        wait_r_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holder_q <= HOLD_NONE;
      wait_l_q <= 1'b0;
      wait_r_q <= 1'b0;
    end else begin
      holder_q <= holder_d;
      wait_l_q <= wait_l_d;
      wait_r_q <= wait_r_d;
    end
  end

  assign own_l = (holder_q == HOLD_LEFT);
  assign own_r = (holder_q == HOLD_RIGHT);

  // R5
  hold_stick_chk: assert property (@(posedge clk) disable iff (rst)
    (own_l && !rel_l) |=> own_l);
  // R7
  left_first_chk: assert property (@(posedge clk) disable iff (rst)
    (holder_q == HOLD_NONE && req_l) |=> own_l);
  // R6
  handover_chk: assert property (@(posedge clk) disable iff (rst)
    (own_l && rel_l && wait_r_q) |=> own_r);
  // R3
  free_nowait_chk: assert property (@(posedge clk) disable iff (rst)
    (holder_q == HOLD_NONE) |-> (!wait_l_q && !wait_r_q));
endmodule

// File: rtl/sem_readback.sv
module sem_readback #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_FLAGS-1:0] mine,
  output logic [DATA_W-1:0]    rdata
);
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '1;
    else if (rd) rdata <= mine[addr] ? '0 : '1;
  end

  // R4
  level_chk: assert property (@(posedge clk) disable iff (rst)
    (rdata == '0) || (rdata == '1));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_FLAGS-1:0] req_l, rel_l, req_r, rel_r;
  logic [NUM_FLAGS-1:0] own_l, own_r;
  logic                 rd_l, rd_r;
  logic                 unused_hi;

  assign unused_hi = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) dec_l (
    .sel(l_sel), .wr(l_wr), .addr(l_addr), .bit0(l_wdata[0]),
    .req(req_l), .rel(rel_l), .rd(rd_l));

  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) dec_r (
    .sel(r_sel), .wr(r_wr), .addr(r_addr), .bit0(r_wdata[0]),
    .req(req_r), .rel(rel_r), .rd(rd_r));

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sem_flag_cell cell_i (
      .clk(clk), .rst(rst),
      .req_l(req_l[g]), .rel_l(rel_l[g]),
      .req_r(req_r[g]), .rel_r(rel_r[g]),
      .own_l(own_l[g]), .own_r(own_r[g]));
  end

  sem_readback #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) rb_l (
    .clk(clk), .rst(rst), .rd(rd_l), .addr(l_addr), .mine(own_l), .rdata(l_rdata));

  sem_readback #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) rb_r (
    .clk(clk), .rst(rst), .rd(rd_r), .addr(r_addr), .mine(own_r), .rdata(r_rdata));

  // R3
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (own_l & own_r) == '0);
  // R9
  untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (req_l == '0 && rel_l == '0 && req_r == '0 && rel_r == '0) |=> $stable(own_l) && $stable(own_r));
  // R1
  reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (l_rdata == '1 && r_rdata == '1 && own_l == '0 && own_r == '0));
endmodule

// File: tb/sem_token_bank_tb.sv
`timescale 1ns/1ps
module sem_token_bank_tb_top;
  localparam int NF = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          l_sel = 0, l_wr = 0, r_sel = 0, r_wr = 0;
  logic [2:0]    l_addr = 0, r_addr = 0;
  logic [DW-1:0] l_wdata = 0, r_wdata = 0;
  logic [DW-1:0] l_rdata, r_rdata;

  always #2 clk = ~clk;

  sem_token_bank dut_i (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model: 0 free, 1 left, 2 right
  int      holder [NF];
  bit      wl [NF];
  bit      wr_ [NF];
  logic [DW-1:0] exp_l, exp_r;

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(bit ls, bit lw, int la, bit ld, bit rs, bit rw, int ra, bit rd);
    if (ls && !lw) exp_l = (holder[la] == 1) ? '0 : '1;
    if (rs && !rw) exp_r = (holder[ra] == 2) ? '0 : '1;
    for (int f = 0; f < NF; f++) begin
      bit ql, el, qr, er;
      ql = ls && lw && la == f && !ld;
      el = ls && lw && la == f &&  ld;
      qr = rs && rw && ra == f && !rd;
      er = rs && rw && ra == f &&  rd;
      if (holder[f] == 0) begin
        if (ql) begin holder[f] = 1; wr_[f] = qr; end
        else if (qr) holder[f] = 2;
      end else if (holder[f] == 1) begin
        wl[f] = 0;
        if (el) begin
          holder[f] = (wr_[f] || qr) ? 2 : 0;
          wr_[f] = 0;
        end else begin
          if (qr) wr_[f] = 1;
          if (er) wr_[f] = 0;
        end
      end else begin
        wr_[f] = 0;
        if (er) begin
          holder[f] = (wl[f] || ql) ? 1 : 0;
          wl[f] = 0;
        end else begin
          if (ql) wl[f] = 1;
          if (el) wl[f] = 0;
        end
      end
    end
  endtask

  task automatic step(string tag, bit ls, bit lw, int la, logic [DW-1:0] ld,
                      bit rs, bit rw, int ra, logic [DW-1:0] rd);
    l_sel = ls; l_wr = lw; l_addr = 3'(la); l_wdata = ld;
    r_sel = rs; r_wr = rw; r_addr = 3'(ra); r_wdata = rd;
    @(posedge clk);
    model_step(ls, lw, la, ld[0], rs, rw, ra, rd[0]);
    #1;
    check(tag, "left rdata", l_rdata, exp_l);
    check(tag, "right rdata", r_rdata, exp_r);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, '0, 0, 0, 0, '0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++) begin holder[f] = 0; wl[f] = 0; wr_[f] = 0; end
    exp_l = '1; exp_r = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #0;
    // R1: reset state at the ports and for every flag
    check("R1", "left rdata after reset", l_rdata, 16'hFFFF);
    check("R1", "right rdata after reset", r_rdata, 16'hFFFF);
    for (int f = 0; f < NF; f++) step("R1", 1, 0, f, '0, 1, 0, f, '0);

    // R2: writes with select low do nothing
    step("R2", 0, 1, 3, 16'h0000, 0, 1, 3, 16'h0000);
    step("R2", 1, 0, 3, '0, 1, 0, 3, '0);
    check("R2", "flag3 left after deselected write", l_rdata, 16'hFFFF);
    // R3: claim with upper bits set, only bit 0 counts
    step("R3", 1, 1, 3, 16'hFFFE, 0, 0, 0, '0);
    step("R3", 1, 0, 3, '0, 1, 0, 3, '0);
    check("R3", "left owns flag3", l_rdata, 16'h0000);
    check("R3", "right sees flag3 taken", r_rdata, 16'hFFFF);
    // R4: hold with no read
    idle("R4");
    check("R4", "left rdata held", l_rdata, 16'h0000);
    // R10: owner re-request
    step("R10", 1, 1, 3, 16'h0000, 0, 0, 0, '0);
    // R5: non-owner release ignored
    step("R5", 0, 0, 0, '0, 1, 1, 3, 16'h0001);
    step("R5", 1, 0, 3, '0, 1, 0, 3, '0);
    check("R5", "left still owns flag3", l_rdata, 16'h0000);
    // R6: right waits, then takes over on left release
    step("R6", 0, 0, 0, '0, 1, 1, 3, 16'h0000);
    step("R6", 1, 1, 3, 16'h0001, 1, 0, 3, '0);
    step("R6", 1, 0, 3, '0, 1, 0, 3, '0);
    check("R6", "right owns flag3 after handover", r_rdata, 16'h0000);
    // R8: left waits then withdraws; right release then frees
    step("R8", 1, 1, 3, 16'h0000, 0, 0, 0, '0);
    step("R8", 1, 1, 3, 16'h0001, 0, 0, 0, '0);
    step("R8", 0, 0, 0, '0, 1, 1, 3, 16'h0001);
    step("R8", 1, 0, 3, '0, 1, 0, 3, '0);
    check("R8", "flag3 free for left", l_rdata, 16'hFFFF);
    // R7: tie on free flag 6
    step("R7", 1, 1, 6, 16'h0000, 1, 1, 6, 16'h0000);
    step("R7", 1, 0, 6, '0, 1, 0, 6, '0);
    check("R7", "left wins tie", l_rdata, 16'h0000);
    step("R7", 1, 1, 6, 16'h0001, 0, 0, 0, '0);
    step("R7", 1, 0, 6, '0, 1, 0, 6, '0);
    check("R7", "queued right owns", r_rdata, 16'h0000);
    // R5: owner release frees; R9: other flags untouched
    step("R5", 0, 0, 0, '0, 1, 1, 6, 16'h0001);
    step("R9", 1, 1, 0, 16'h0000, 1, 1, 7, 16'h0000);
    step("R9", 1, 0, 7, '0, 1, 0, 0, '0);
    check("R9", "left does not own flag7", l_rdata, 16'hFFFF);
    check("R9", "right does not own flag0", r_rdata, 16'hFFFF);
    step("R9", 1, 0, 6, '0, 1, 0, 6, '0);

    // random phase on a narrowed address set, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      int ls, lw, rs, rw;
      ls = ($urandom % 4) != 0; lw = $urandom % 2;
      rs = ($urandom % 4) != 0; rw = $urandom % 2;
      step("R9", 1'(ls), 1'(lw), $urandom % 3, 16'($urandom),
                 1'(rs), 1'(rw), $urandom % 3, 16'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule